// File: doc/BRIEF.md
# Long Vector Delta Unit

This block executes the operand phase of a long-vector drawing instruction in a vector display processor. Once the instruction fetcher has read the opcode word, it hands the two operand words that follow to this unit, along with the address of the opcode word and the current beam position. The first operand word carries the line attributes and one magnitude. The second carries the two direction signs, an axis-select flag and the other magnitude. The unit decides which magnitude moves X and which moves Y. It applies each magnitude toward the positive or negative side of its axis and produces the updated position. It also raises a single-cycle draw request that carries the old and new endpoints and the line attributes.

The operand pair arrives on a valid/ready stream. The unit applies no back-pressure of its own: `in_ready` is high in every cycle outside reset, and each accepted pair is fully processed in one registered stage. The result appears in the cycle after acceptance. Pairs may arrive back to back. `draw_stb` is a plain one-cycle strobe with no ready. A consumer that cannot take a strobe must hold off `in_valid`. The updated position and the program-counter value for the next instruction stay on their outputs until the next pair is accepted.

Top module: `lvec_delta_unit`

## Requirements
- R1: In `op_word_a`, bit 14 is the dotted-line flag, bit 13 is the beam-on flag, and bits 11:0 are magnitude M. Bits 15 and 12 are ignored.
- R2: In `op_word_b`, bit 14 makes the X move negative, bit 13 makes the Y move negative, bit 12 is the axis-swap flag, and bits 11:0 are magnitude N. Bit 15 is ignored.
- R3: With the swap flag clear, M moves X and N moves Y. With it set, N moves X and M moves Y.
- R4: For each axis, a set sign bit subtracts that axis's magnitude from the current coordinate, and a clear sign bit adds it. A zero magnitude leaves that coordinate unchanged.
- R5: Coordinates are 11 bits wide and every result wraps modulo 2048. This includes magnitudes of 2048 or more and moves that cross 0 or 2047.
- R6: `in_ready` is 1 whenever `rst` is low. Every cycle with `in_valid` and `in_ready` both high produces exactly one cycle of `draw_stb` in the next cycle. In all other cycles `draw_stb` is 0.
- R7: In the strobe cycle, `draw_x0`/`draw_y0` equal `cur_x`/`cur_y` as sampled at acceptance, and `draw_x1`/`draw_y1` and `new_x`/`new_y` hold the updated position. `new_x`/`new_y` keep that value until the next acceptance.
- R8: `draw_dot` and `draw_beam` carry the dotted and beam-on flags of the accepted pair.
- R9: `pc_next` equals the accepted `op_pc` plus 3, modulo 4096. This steps past the opcode word and both operand words.
- R10: While `rst` is high, and in the cycle after it, all outputs except `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit accepts the pair this cycle |
| op_word_a | input | 16 | Attribute and magnitude M word |
| op_word_b | input | 16 | Sign, swap and magnitude N word |
| op_pc | input | 12 | Address of the opcode word |
| cur_x | input | 11 | Current X position |
| cur_y | input | 11 | Current Y position |
| new_x | output | 11 | Updated X position |
| new_y | output | 11 | Updated Y position |
| pc_next | output | 12 | Address of the following instruction |
| draw_stb | output | 1 | One-cycle draw request |
| draw_x0 | output | 11 | Line start X |
| draw_y0 | output | 11 | Line start Y |
| draw_x1 | output | 11 | Line end X |
| draw_y1 | output | 11 | Line end Y |
| draw_dot | output | 1 | Dotted-line attribute |
| draw_beam | output | 1 | Beam-on attribute |

## Verification
The bench targets the swap flag combined with each sign pattern. A design that inverted the swap or tied a sign to the wrong axis would move the right distance in the wrong direction or on the wrong axis. Magnitudes at and above 2048, and moves across 0 and 2047, expose any adder that saturates or keeps a twelfth bit. Words with the ignored bits set show whether those bits leak into the flags. Back-to-back pairs, idle gaps and a program counter near 4095 show whether the unit drops or repeats strobes, lets the held position drift, or fails to wrap the next-instruction address.

// File: rtl/lvec_pkg.sv
package lvec_pkg;
  localparam int WORD_W     = 16;
  localparam int MAG_W      = 12;
  localparam int A_DOT_BIT  = 14;
  localparam int A_BEAM_BIT = 13;
  localparam int B_XNEG_BIT = 14;
  localparam int B_YNEG_BIT = 13;
  localparam int B_SWAP_BIT = 12;
  localparam int N_AXES     = 2;
  localparam int AXIS_X     = 0;
  localparam int AXIS_Y     = 1;
  localparam int INSN_WORDS = 3;

  typedef struct packed {
    logic             dotted;
    logic             beam;
    logic             x_neg;
    logic             y_neg;
    logic             swap;
    logic [MAG_W-1:0] mag_m;
    logic [MAG_W-1:0] mag_n;
  } lvec_fields_t;
endpackage

// File: rtl/lvec_operand_decode.sv
module lvec_operand_decode
  import lvec_pkg::*;
(
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output lvec_fields_t      fields
);
  always_comb begin
    fields.dotted = word_a[A_DOT_BIT];
    fields.beam   = word_a[A_BEAM_BIT];
    fields.mag_m  = word_a[MAG_W-1:0];
    fields.x_neg  = word_b[B_XNEG_BIT];
    fields.y_neg  = word_b[B_YNEG_BIT];
    fields.swap   = word_b[B_SWAP_BIT];
    fields.mag_n  = word_b[MAG_W-1:0];
  end
endmodule

// File: rtl/lvec_axis_steer.sv
module lvec_axis_steer
  import lvec_pkg::*;
(
  input  lvec_fields_t                   fields,
  output logic [N_AXES-1:0][MAG_W-1:0]   axis_mag,
  output logic [N_AXES-1:0]              axis_neg
);
  always_comb begin
    axis_mag[AXIS_X] = fields.swap ? fields.mag_n : fields.mag_m;
    axis_mag[AXIS_Y] = fields.swap ? fields.mag_m : fields.mag_n;
    axis_neg[AXIS_X] = fields.x_neg;
    axis_neg[AXIS_Y] = fields.y_neg;
  end

  // R3: the two axes always draw on the two distinct magnitudes
  always_comb begin
    assert_steer_pair_R3: assert ((axis_mag[AXIS_X] ^ axis_mag[AXIS_Y]) ==
                                  (fields.mag_m ^ fields.mag_n));
  end
endmodule

// File: rtl/lvec_axis_step.sv
module lvec_axis_step
  import lvec_pkg::*;
#(
  parameter int COORD_W = 11
) (
  input  logic [COORD_W-1:0] base,
  input  logic [MAG_W-1:0]   mag,
  input  logic               neg,
  output logic [COORD_W-1:0] res
);
  logic [COORD_W-1:0] mag_t;

  generate
    if (MAG_W >= COORD_W) begin : g_trunc
      assign mag_t = mag[COORD_W-1:0];
    end else begin : g_ext
      assign mag_t = {{(COORD_W-MAG_W){1'b0}}, mag};
    end
  endgenerate

  always_comb begin
    if (neg) res = base - mag_t;
    else     res = base + mag_t;
  end

  always_comb begin
    if (mag == '0) begin
      assert_zero_move_R4: assert (res == base);
    end
  end
endmodule

// File: rtl/lvec_delta_unit.sv
module lvec_delta_unit
  import lvec_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int ADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   op_word_a,
  input  logic [WORD_W-1:0]   op_word_b,
  input  logic [ADDR_W-1:0]   op_pc,
  input  logic [COORD_W-1:0]  cur_x,
  input  logic [COORD_W-1:0]  cur_y,
  output logic [COORD_W-1:0]  new_x,
  output logic [COORD_W-1:0]  new_y,
  output logic [ADDR_W-1:0]   pc_next,
  output logic                draw_stb,
  output logic [COORD_W-1:0]  draw_x0,
  output logic [COORD_W-1:0]  draw_y0,
  output logic [COORD_W-1:0]  draw_x1,
  output logic [COORD_W-1:0]  draw_y1,
  output logic                draw_dot,
  output logic                draw_beam
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSN_WORDS);

  lvec_fields_t                    fields;
  logic [N_AXES-1:0][MAG_W-1:0]    axis_mag;
  logic [N_AXES-1:0]               axis_neg;
  logic [N_AXES-1:0][COORD_W-1:0]  axis_base;
  logic [N_AXES-1:0][COORD_W-1:0]  axis_res;
  logic                            accept;

  logic [COORD_W-1:0] q_x, q_y, q_x0, q_y0;
  logic [ADDR_W-1:0]  q_pc;
  logic               q_stb, q_dot, q_beam;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;

  lvec_operand_decode u_decode (
    .word_a (op_word_a),
    .word_b (op_word_b),
    .fields (fields)
  );

  lvec_axis_steer u_steer (
    .fields   (fields),
    .axis_mag (axis_mag),
    .axis_neg (axis_neg)
  );

  assign axis_base[AXIS_X] = cur_x;
  assign axis_base[AXIS_Y] = cur_y;

  generate
    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
      lvec_axis_step #(.COORD_W(COORD_W)) u_step (
        .base (axis_base[a]),
        .mag  (axis_mag[a]),
        .neg  (axis_neg[a]),
        .res  (axis_res[a])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_x    <= '0;
      q_y    <= '0;
      q_x0   <= '0;
      q_y0   <= '0;
      q_pc   <= '0;
      q_stb  <= 1'b0;
      q_dot  <= 1'b0;
      q_beam <= 1'b0;
    end else begin
      q_stb <= accept;
      if (accept) begin
        q_x    <= axis_res[AXIS_X];
        q_y    <= axis_res[AXIS_Y];
        q_x0   <= cur_x;
        q_y0   <= cur_y;
        q_pc   <= op_pc + PC_STEP;
        q_dot  <= fields.dotted;
        q_beam <= fields.beam;
      end
    end
  end

  assign new_x     = q_x;
  assign new_y     = q_y;
  assign draw_x1   = q_x;
  assign draw_y1   = q_y;
  assign draw_x0   = q_x0;
  assign draw_y0   = q_y0;
  assign pc_next   = q_pc;
  assign draw_stb  = q_stb;
  assign draw_dot  = q_dot;
  assign draw_beam = q_beam;

  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> draw_stb);

  assert_strobe_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    draw_stb |-> $past(in_valid));

  assert_start_point_R7: assert property (@(posedge clk) disable iff (rst)
    draw_stb |-> (draw_x0 == $past(cur_x)) && (draw_y0 == $past(cur_y)));

  assert_position_held_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(new_x) && $stable(new_y));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    draw_stb |-> pc_next == ADDR_W'($past(op_pc) + PC_STEP));
endmodule

// File: tb/sim_lvec_delta_unit.sv
module sim_lvec_delta_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] op_word_a = '0, op_word_b = '0;
  logic [11:0] op_pc = '0;
  logic [10:0] cur_x = '0, cur_y = '0;
  logic [10:0] new_x, new_y, draw_x0, draw_y0, draw_x1, draw_y1;
  logic [11:0] pc_next;
  logic        draw_stb, draw_dot, draw_beam;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R10 reset";

  // reference state
  int e_x = 0, e_y = 0, e_x0 = 0, e_y0 = 0, e_pc = 0, e_stb = 0, e_dot = 0, e_beam = 0;

  always #2 clk = ~clk;

  lvec_delta_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_word_a(op_word_a), .op_word_b(op_word_b), .op_pc(op_pc),
    .cur_x(cur_x), .cur_y(cur_y), .new_x(new_x), .new_y(new_y),
    .pc_next(pc_next), .draw_stb(draw_stb), .draw_x0(draw_x0),
    .draw_y0(draw_y0), .draw_x1(draw_x1), .draw_y1(draw_y1),
    .draw_dot(draw_dot), .draw_beam(draw_beam)
  );

  always @(posedge clk) begin
    if (rst) begin
      e_x = 0; e_y = 0; e_x0 = 0; e_y0 = 0; e_pc = 0; e_stb = 0; e_dot = 0; e_beam = 0;
    end else begin
      e_stb = in_valid;
      if (in_valid) begin
        int m, n, dx, dy;
        m = op_word_a & 12'hFFF;
        n = op_word_b & 12'hFFF;
        if (op_word_b[12]) begin dx = n; dy = m; end
        else               begin dx = m; dy = n; end
        if (op_word_b[14]) dx = -dx;
        if (op_word_b[13]) dy = -dy;
        e_x0   = cur_x;
        e_y0   = cur_y;
        e_x    = (int'(cur_x) + dx) & 2047;
        e_y    = (int'(cur_y) + dy) & 2047;
        e_pc   = (int'(op_pc) + 3) & 4095;
        e_dot  = op_word_a[14];
        e_beam = op_word_a[13];
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("in_ready R6", in_ready, rst ? 0 : 1);
    chk("draw_stb R6", draw_stb, e_stb);
    chk("new_x R3 R4 R5", new_x, e_x);
    chk("new_y R3 R4 R5", new_y, e_y);
    chk("draw_x1 R7", draw_x1, e_x);
    chk("draw_y1 R7", draw_y1, e_y);
    chk("draw_x0 R7", draw_x0, e_x0);
    chk("draw_y0 R7", draw_y0, e_y0);
    chk("pc_next R9", pc_next, e_pc);
    chk("draw_dot R1 R8", draw_dot, e_dot);
    chk("draw_beam R1 R8", draw_beam, e_beam);
  endtask

  // compare at the negedge, then drive the next cycle's inputs
  task automatic cyc(input bit v, input logic [15:0] a, input logic [15:0] b,
                     input int pc, input int x, input int y);
    @(negedge clk);
    compare_all();
    in_valid  = v;
    op_word_a = a;
    op_word_b = b;
    op_pc     = 12'(pc);
    cur_x     = 11'(x);
    cur_y     = 11'(y);
  endtask

  task automatic idle();
    cyc(1'b0, 16'hFFFF, 16'hFFFF, 4095, 2047, 2047);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    tag = "R10 reset";
    for (int i = 0; i < 3; i++) idle();
    rst = 1'b0;
    idle();
    idle();

    tag = "R3 no swap, R4 positive";
    cyc(1, 16'h0064, 16'h00C8, 10, 500, 600);       // X+100, Y+200
    idle();
    tag = "R3 swap set";
    cyc(1, 16'h0064, 16'h10C8, 20, 500, 600);       // X+200, Y+100
    idle();
    tag = "R4 both negative";
    cyc(1, 16'h0010, 16'h6020, 30, 1000, 1000);
    idle();
    tag = "R4 swap with X negative only";
    cyc(1, 16'h0005, 16'h5009, 40, 100, 100);
    tag = "R4 zero magnitudes";
    cyc(1, 16'h0000, 16'h7000, 41, 77, 1234);
    idle();
    tag = "R5 wrap past 2047";
    cyc(1, 16'h0010, 16'h0020, 50, 2040, 2030);
    tag = "R5 wrap below 0";
    cyc(1, 16'h0003, 16'h6005, 51, 1, 2);
    tag = "R5 magnitude above 2047";
    cyc(1, 16'h0FFF, 16'h0801, 52, 5, 9);
    tag = "R5 large negative";
    cyc(1, 16'h0FFF, 16'h7FFF, 53, 0, 2047);
    idle();
    tag = "R1 R2 R8 ignored bits and flags";
    cyc(1, 16'h9000, 16'h8000, 60, 300, 300);       // no flags, no move
    cyc(1, 16'hC001, 16'h0002, 61, 300, 300);       // dotted only
    cyc(1, 16'hA001, 16'h8002, 62, 300, 300);       // beam only
    cyc(1, 16'h7FFF, 16'h8000, 63, 300, 300);
    idle();
    tag = "R9 pc wrap";
    cyc(1, 16'h0001, 16'h0001, 4094, 10, 10);
    cyc(1, 16'h0001, 16'h0001, 4095, 10, 10);
    idle();
    tag = "R7 hold across idle";
    for (int i = 0; i < 4; i++) idle();

    tag = "R6 mixed stream";
    for (int i = 0; i < 300; i++) begin
      cyc(($urandom % 3) != 0, 16'($urandom), 16'($urandom), int'($urandom % 4096),
          int'($urandom % 2048), int'($urandom % 2048));
    end
    tag = "R10 reset mid stream";
    cyc(1, 16'h6123, 16'h7456, 7, 9, 9);
    rst = 1'b1;
    idle();
    idle();
    rst = 1'b0;
    idle();
    idle();
    done = 1;
    finish_up();
  end
endmodule